// File: doc/BRIEF.md
# Bank Interlock Arbiter

This block sits in front of a set of independently cycling memory banks and decides, at every bank-cycle boundary, which requester may start an access on which bank. Every requester presents a valid bit and the number of the bank it wants. When the cycle strobe is high, each bank grants at most one of the requesters aimed at it. Every other requester aimed at that bank is reported as locked out and is expected to try again at a later boundary. The grant and lockout vectors and the per-bank busy flags are registered. They hold their values for the whole bank cycle.

Requesters belong to three fixed classes. The DMA synchronizers have the lowest indices and the highest rank, the I/O processor comes next, and the compute processors have the highest indices and the lowest rank. If a DMA or I/O-processor requester loses, its bank records a reservation. From then on, requesters of a strictly lower class cannot start on that bank until the reserving requester has been granted and its access has completed a fixed number of bank cycles later. If the reserving requester withdraws before it is granted, the reservation is dropped. This keeps the upper classes from being starved by a stream of compute traffic.

Top module: `bank_interlock_arbiter`

## Requirements
- R1: Reset clears every grant, lockout and busy output and every reservation, so a compute requester is granted on a bank that was reserved before the reset.
- R2: A lone requester aimed at a free, unreserved bank has its grant bit set by the strobe, and the busy flag of that bank is set at the same time.
- R3: Grant, lockout and busy outputs change only on a clock edge at which the strobe is high. Between strobes they hold, whatever the request inputs do.
- R4: Requester indices are assigned as DMA 0..NUM_DMA-1, then I/O processor, then compute. Among requesters eligible for the same bank the lowest index wins, and each bank grants at most one requester per strobe.
- R5: The lockout bit of a requester is set exactly when it requested a valid bank at the strobe and was not granted. Idle requesters show neither grant nor lockout.
- R6: Requests aimed at different banks are decided independently, so distinct-bank requests are all granted in the same strobe.
- R7: A locked-out DMA or I/O-processor requester reserves its bank if the bank holds no live reservation. Strictly lower classes are then locked out of that bank until LAT_CYC strobes after the reserving requester's grant.
- R8: A reservation never bars requesters of the same or a higher class than the reserving one.
- R9: A reservation whose requester, before being granted, drops its request or asks for another bank is cleared at that strobe, and lower classes may win the bank in that same strobe.
- R10: The busy flag of a bank is set for the cycle after a strobe that granted an access on it, and is clear otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb_i | input | 1 | Bank-cycle boundary strobe |
| req_vld_i | input | NUM_REQ | Per-requester request valid |
| req_bank_i | input | NUM_REQ*BW | Per-requester bank number, requester r in bits [r*BW +: BW] |
| gnt_o | output | NUM_REQ | Per-requester grant for the current bank cycle |
| lock_o | output | NUM_REQ | Per-requester lockout for the current bank cycle |
| busy_o | output | NUM_BANKS | Per-bank busy flag for the current bank cycle |

## Verification
The first patterns are directed. A lone request and requests spread over distinct banks show whether banks are decided independently. Several requesters piled onto one bank show whether priority follows the index. Three short sequences show that a reservation bars only lower classes, that it expires exactly LAT_CYC strobes after the reserving requester's grant, and that withdrawing the request clears it. A long pseudo-random sweep then crowds all requesters onto three banks and mixes strobe cycles with idle cycles. This produces overlapping reservations, retries and withdrawals, and the bench checks each outcome against an arithmetic model of the rules.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

  typedef enum logic [1:0] {
    CLS_DMA = 2'd0,
    CLS_IOP = 2'd1,
    CLS_CPU = 2'd2
  } req_class_e;

  // Requester index to priority class: DMA indices first, then I/O processor, then compute
  function automatic req_class_e class_of(input int unsigned idx,
                                          input int unsigned n_dma,
                                          input int unsigned n_iop);
    if (idx < n_dma)              return CLS_DMA;
    else if (idx < n_dma + n_iop) return CLS_IOP;
    else                          return CLS_CPU;
  endfunction

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        idx_o       = IW'(i);
      end
    end
  end

  assign any_o = |vec_i;

endmodule

// File: rtl/bank_slot.sv
module bank_slot
  import bank_arb_pkg::*;
#(
  parameter int NUM_REQ = 5,
  parameter int NUM_DMA = 2,
  parameter int NUM_IOP = 1,
  parameter int BW      = 3,
  parameter int IW      = 3,
  parameter int LAT_CYC = 2,
  parameter int BANK_ID = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stb_i,
  input  logic [NUM_REQ-1:0]    req_vld_i,
  input  logic [NUM_REQ*BW-1:0] req_bank_i,
  output logic [NUM_REQ-1:0]    win_o
);

  localparam int CW = (LAT_CYC > 1) ? $clog2(LAT_CYC + 1) : 1;

  logic [NUM_REQ-1:0] hit, cpu_m, barred, elig, lockv, resv_cand, resv_oh;
  logic [IW-1:0]      resv_idx, res_id;
  logic               resv_any, win_any;
  logic [IW-1:0]      win_idx;
  logic               res_v, res_g, res_done, res_wd, res_live;
  logic [CW-1:0]      res_cnt;
  req_class_e         res_cls;

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    assign hit[r]   = req_vld_i[r] && (req_bank_i[r*BW +: BW] == BW'(BANK_ID));
    assign cpu_m[r] = (class_of(r, NUM_DMA, NUM_IOP) == CLS_CPU);
  end

  always_comb begin
    res_cls  = class_of(int'(res_id), NUM_DMA, NUM_IOP);
    res_done = res_v && res_g && (res_cnt == CW'(1));
    res_wd   = res_v && !res_g && !hit[res_id];
    res_live = res_v && !res_done && !res_wd;
    for (int r = 0; r < NUM_REQ; r++)
      barred[r] = res_live && (class_of(r, NUM_DMA, NUM_IOP) > res_cls);
  end

  assign elig      = hit & ~barred;
  assign lockv     = hit & ~win_o;
  assign resv_cand = lockv & ~cpu_m;

  prio_pick #(.N(NUM_REQ), .IW(IW)) i_win_pick (
    .vec_i(elig), .onehot_o(win_o), .idx_o(win_idx), .any_o(win_any)
  );

  prio_pick #(.N(NUM_REQ), .IW(IW)) i_resv_pick (
    .vec_i(resv_cand), .onehot_o(resv_oh), .idx_o(resv_idx), .any_o(resv_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_v   <= 1'b0;
      res_g   <= 1'b0;
      res_id  <= '0;
      res_cnt <= '0;
    end else if (stb_i) begin
      if (res_live) begin
        if (!res_g && win_o[res_id]) begin
          res_g   <= 1'b1;
          res_cnt <= CW'(LAT_CYC);
        end else if (res_g) begin
          res_cnt <= res_cnt - CW'(1);
        end
      end else if (resv_any) begin
        res_v  <= 1'b1;
        res_g  <= 1'b0;
        res_id <= resv_idx;
      end else begin
        res_v <= 1'b0;
        res_g <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bank_interlock_arbiter.sv
module bank_interlock_arbiter #(
  parameter int NUM_BANKS = 8,
  parameter int NUM_DMA   = 2,
  parameter int NUM_IOP   = 1,
  parameter int NUM_CPU   = 2,
  parameter int LAT_CYC   = 2,
  localparam int NUM_REQ  = NUM_DMA + NUM_IOP + NUM_CPU,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IW       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cyc_stb_i,
  input  logic [NUM_REQ-1:0]    req_vld_i,
  input  logic [NUM_REQ*BW-1:0] req_bank_i,
  output logic [NUM_REQ-1:0]    gnt_o,
  output logic [NUM_REQ-1:0]    lock_o,
  output logic [NUM_BANKS-1:0]  busy_o
);

  logic [NUM_REQ-1:0]   win_bank [NUM_BANKS];
  logic [NUM_REQ-1:0]   gnt_nx, lock_nx, hit_any;
  logic [NUM_BANKS-1:0] busy_nx;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_slot #(
      .NUM_REQ(NUM_REQ), .NUM_DMA(NUM_DMA), .NUM_IOP(NUM_IOP),
      .BW(BW), .IW(IW), .LAT_CYC(LAT_CYC), .BANK_ID(b)
    ) i_slot (
      .clk(clk), .rst(rst), .stb_i(cyc_stb_i),
      .req_vld_i(req_vld_i), .req_bank_i(req_bank_i),
      .win_o(win_bank[b])
    );
    assign busy_nx[b] = |win_bank[b];
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_valid
    assign hit_any[r] = req_vld_i[r] && (int'(req_bank_i[r*BW +: BW]) < NUM_BANKS);
  end

  always_comb begin
    gnt_nx = '0;
    for (int b = 0; b < NUM_BANKS; b++) gnt_nx = gnt_nx | win_bank[b];
    lock_nx = hit_any & ~gnt_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o  <= '0;
      lock_o <= '0;
      busy_o <= '0;
    end else if (cyc_stb_i) begin
      gnt_o  <= gnt_nx;
      lock_o <= lock_nx;
      busy_o <= busy_nx;
    end
  end

endmodule

// File: rtl/bank_interlock_arbiter_chk.sv
module bank_interlock_arbiter_chk #(
  parameter int NUM_BANKS = 8,
  parameter int NUM_DMA   = 2,
  parameter int NUM_IOP   = 1,
  parameter int NUM_CPU   = 2,
  parameter int LAT_CYC   = 2,
  localparam int NUM_REQ  = NUM_DMA + NUM_IOP + NUM_CPU,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cyc_stb_i,
  input logic [NUM_REQ-1:0]    req_vld_i,
  input logic [NUM_REQ*BW-1:0] req_bank_i,
  input logic [NUM_REQ-1:0]    gnt_o,
  input logic [NUM_REQ-1:0]    lock_o,
  input logic [NUM_BANKS-1:0]  busy_o
);

  logic [NUM_REQ-1:0]    req_q;
  logic [NUM_REQ*BW-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      bank_q <= '0;
    end else if (cyc_stb_i) begin
      req_q  <= req_vld_i;
      bank_q <= req_bank_i;
    end
  end

  // R3
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_stb_i |=> ($stable(gnt_o) && $stable(lock_o) && $stable(busy_o)));

  // R5
  gnt_lock_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & lock_o) == '0);

  // R5
  lock_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_o & ~req_q) == '0);

  // R5
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & ~req_q) == '0);

  for (genvar s = 0; s < NUM_REQ; s++) begin : g_s
    // R10
    gnt_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_o[s] |-> busy_o[bank_q[s*BW +: BW]]);
    for (genvar r = 0; r < s; r++) begin : g_r
      // R4
      lower_index_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_o[s] && req_q[r]) |-> (bank_q[r*BW +: BW] != bank_q[s*BW +: BW]));
    end
  end

endmodule

bind bank_interlock_arbiter bank_interlock_arbiter_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_DMA(NUM_DMA), .NUM_IOP(NUM_IOP),
  .NUM_CPU(NUM_CPU), .LAT_CYC(LAT_CYC)
) i_chk (.*);

// File: tb/test_bank_interlock_arbiter.sv
module test_bank_interlock_arbiter;

  localparam int NB  = 8;
  localparam int ND  = 2;
  localparam int NI  = 1;
  localparam int NC  = 2;
  localparam int LAT = 2;
  localparam int NR  = ND + NI + NC;
  localparam int BW  = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           stb = 1'b0;
  logic [NR-1:0]  req = '0;
  logic [NR*BW-1:0] bank = '0;
  logic [NR-1:0]  gnt, lock;
  logic [NB-1:0]  busy;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // model state
  int m_rv [NB];
  int m_rid[NB];
  int m_rg [NB];
  int m_rc [NB];
  logic [NR-1:0] e_gnt  = '0;
  logic [NR-1:0] e_lock = '0;
  logic [NB-1:0] e_busy = '0;
  int bk[NR];
  int unsigned lfsr = 32'hACE1_2357;

  bank_interlock_arbiter #(
    .NUM_BANKS(NB), .NUM_DMA(ND), .NUM_IOP(NI), .NUM_CPU(NC), .LAT_CYC(LAT)
  ) i_bank_interlock_arbiter (
    .clk(clk), .rst(rst), .cyc_stb_i(stb), .req_vld_i(req), .req_bank_i(bank),
    .gnt_o(gnt), .lock_o(lock), .busy_o(busy)
  );

  always #10 clk = ~clk;

  function automatic int cls(input int i);
    if (i < ND) return 0;
    else if (i < ND + NI) return 1;
    else return 2;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_rv[b] = 0; m_rid[b] = 0; m_rg[b] = 0; m_rc[b] = 0;
    end
    e_gnt = '0; e_lock = '0; e_busy = '0;
  endtask

  task automatic model_strobe();
    e_gnt = '0; e_lock = '0; e_busy = '0;
    for (int b = 0; b < NB; b++) begin
      int  win;
      int  rsv;
      bit  live;
      live = (m_rv[b] != 0)
          && !(m_rg[b] != 0 && m_rc[b] == 1)
          && !(m_rg[b] == 0 && !(req[m_rid[b]] && bk[m_rid[b]] == b));
      win = -1;
      for (int r = 0; r < NR; r++)
        if (win < 0 && req[r] && bk[r] == b && !(live && cls(r) > cls(m_rid[b])))
          win = r;
      if (win >= 0) begin
        e_gnt[win] = 1'b1;
        e_busy[b]  = 1'b1;
      end
      rsv = -1;
      for (int r = 0; r < NR; r++)
        if (req[r] && bk[r] == b && r != win) begin
          e_lock[r] = 1'b1;
          if (rsv < 0 && cls(r) < 2) rsv = r;
        end
      if (live) begin
        if (m_rg[b] == 0 && win == m_rid[b]) begin
          m_rg[b] = 1; m_rc[b] = LAT;
        end else if (m_rg[b] != 0) begin
          m_rc[b] = m_rc[b] - 1;
        end
      end else if (rsv >= 0) begin
        m_rv[b] = 1; m_rid[b] = rsv; m_rg[b] = 0;
      end else begin
        m_rv[b] = 0; m_rg[b] = 0;
      end
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "grant",   16'(gnt),  16'(e_gnt));
    chk(tag, "lockout", 16'(lock), 16'(e_lock));
    chk(tag, "busy",    16'(busy), 16'(e_busy));
  endtask

  task automatic pack_bank();
    for (int r = 0; r < NR; r++) bank[r*BW +: BW] = BW'(bk[r]);
  endtask

  task automatic do_stb(input logic [NR-1:0] rq, input int b0, input int b1,
                        input int b2, input int b3, input int b4, input string tag);
    @(negedge clk);
    bk[0] = b0; bk[1] = b1; bk[2] = b2; bk[3] = b3; bk[4] = b4;
    req = rq;
    pack_bank();
    stb = 1'b1;
    model_strobe();
    @(negedge clk);
    stb = 1'b0;
    check_all(tag);
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hD000_0001 : 32'h0);
    req  = NR'(lfsr);
    bank = (NR*BW)'(lfsr >> 7);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stb = 1'b0; req = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    model_reset();
    for (int r = 0; r < NR; r++) bk[r] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R2 lone compute request
    do_stb(5'b01000, 0, 0, 0, 3, 0, "R2");
    chk("R2", "grant r3", 16'(gnt[3]), 16'd1);
    chk("R10", "busy bank3", 16'(busy[3]), 16'd1);
    do_idle("R3");
    do_idle("R3");

    // R4 / R5 three on bank 4
    do_stb(5'b11001, 4, 0, 0, 4, 4, "R4");
    chk("R5", "lockout r3 r4", 16'(lock), 16'b11000);

    // R6 all distinct banks
    do_stb(5'b11111, 0, 1, 2, 3, 4, "R6");
    chk("R6", "all granted", 16'(gnt), 16'b11111);

    // R7 I/O processor reservation bars compute
    do_stb(5'b00101, 5, 0, 5, 0, 0, "R7");
    do_stb(5'b01100, 0, 0, 5, 5, 0, "R7");
    do_stb(5'b01000, 0, 0, 0, 5, 0, "R7");
    chk("R7", "compute barred", 16'(lock[3]), 16'd1);
    do_stb(5'b01000, 0, 0, 0, 5, 0, "R7");
    chk("R7", "compute after expiry", 16'(gnt[3]), 16'd1);

    // R8 DMA reservation does not bar other DMA
    do_stb(5'b00011, 6, 6, 0, 0, 0, "R8");
    do_stb(5'b00010, 0, 6, 0, 0, 0, "R8");
    do_stb(5'b00101, 6, 0, 6, 0, 0, "R8");
    chk("R8", "DMA0 on reserved bank", 16'(gnt[0]), 16'd1);
    do_stb(5'b00100, 0, 0, 6, 0, 0, "R7");

    // R9 withdrawal
    do_stb(5'b00101, 7, 0, 7, 0, 0, "R9");
    do_stb(5'b10100, 0, 0, 1, 0, 7, "R9");
    chk("R9", "compute after withdraw", 16'(gnt[4]), 16'd1);

    // R1 reset drops a reservation
    do_stb(5'b00101, 2, 0, 2, 0, 0, "R1");
    do_reset();
    check_all("R1");
    do_stb(5'b01000, 0, 0, 0, 2, 0, "R1");
    chk("R1", "compute after reset", 16'(gnt[3]), 16'd1);

    // sweep crowded onto three banks
    for (int n = 0; n < 600; n++) begin
      logic [NR-1:0] rq;
      int bb[NR];
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hD000_0001 : 32'h0);
      rq = NR'(lfsr >> 3);
      for (int r = 0; r < NR; r++) bb[r] = int'((lfsr >> (9 + 2*r)) % 3) + 5;
      if ((n % 5) == 4) do_idle("R3");
      else do_stb(rq, bb[0], bb[1], bb[2], bb[3], bb[4], "R4");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule